// File: doc/BRIEF.md
# Maskable Interrupt Request Controller

This block collects fifteen peripheral interrupt sources for a small CPU core. Each source presents a level. A rising edge on that level, after synchronisation, latches a pending bit for the source. Software sees the pending bits and a matching set of mask bits through a byte-wide register bus. The pending bits sit in two bytes at 0x3C and 0x3D, and the mask bits sit in the two bytes that follow at 0x3E and 0x3F.

A pending bit that is also unmasked asks the CPU for service. The request is made only while the global disable flag is clear. The flag stands for bit 2 of the processor status, and two strobes set it and clear it. When several sources are eligible, the lowest source index wins. Its 4-bit index is presented together with the request.

When the CPU acknowledges, the block does two things in the same clock edge. It clears the winner's pending bit, and it sets the disable flag. A second interrupt is therefore taken only after software clears the flag again inside the handler.

Top module: `mirq_ctrl`

## Requirements
- R1: After reset, every pending bit, every mask bit and the disable flag are 0. All four register bytes read 0x00 and `irq_take_o` is low.
- R2: A rising edge on `src_lvl_i[i]` sets pending bit i three clock edges later, whatever the state of its mask bit. Source i maps to bit i of 0x3C when i < 8, and to bit i-8 of 0x3D otherwise.
- R3: A pending bit whose mask bit is 0 stays at 1 until it is cleared. It does not raise `irq_take_o`, and it does not win arbitration.
- R4: A bus write to 0x3C or 0x3D clears the pending bits whose data bit is 0. Data bits of 1 leave the pending bits unchanged, so a write can never set a pending bit.
- R5: Mask bits are written at 0x3E and 0x3F, using the same bit position per source as the pending bytes. Bit 7 of 0x3D and of 0x3F always reads 0. Any other address reads 0x00.
- R6: `irq_take_o` is high exactly when some source is both pending and unmasked and the disable flag is 0.
- R7: `irq_vec_o` gives the lowest index among the sources that are both pending and unmasked.
- R8: A cycle with `cpu_ack_i` and `irq_take_o` both high clears the winner's pending bit and sets the disable flag at the next edge.
- R9: If a source's new event and the clear from an acknowledge reach the same pending bit on the same edge, the bit ends at 1.
- R10: `sei_i` sets the disable flag and `cli_i` clears it. The flag is visible on `iflag_o`. When both strobes arrive in one cycle, the flag ends at 1.
- R11: After an acknowledge, no further request is raised until `cli_i` clears the flag. Then the next eligible source is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_lvl_i | input | 15 | Interrupt source levels, asynchronous to the clock |
| bus_addr_i | input | 8 | Register byte address |
| bus_wr_i | input | 1 | Write strobe for the register bus |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for `bus_addr_i`, combinational |
| sei_i | input | 1 | Strobe that sets the disable flag |
| cli_i | input | 1 | Strobe that clears the disable flag |
| cpu_ack_i | input | 1 | CPU acknowledge of the offered interrupt |
| irq_take_o | output | 1 | Interrupt request to the CPU |
| irq_vec_o | output | 4 | Index of the winning source |
| iflag_o | output | 1 | Global disable flag |

## Verification
Every piece of state in this block is visible within one cycle, either through a register read or on `irq_take_o` and `iflag_o`. A pending bit that is lost, that self-clears or that can be set by a write shows up in the very next read of its byte. It also shows when `irq_take_o` falls where the bench expects it to stay high. A wrong priority or a wrong acknowledge clear shows up in two ways: as a wrong `irq_vec_o` in the same cycle, and as the wrong pending bit missing in the read after the acknowledge. A disable flag that fails to set on an acknowledge lets `irq_take_o` stay high one edge later, which the nesting sequence catches directly.

// File: rtl/mirq_pkg.sv
package mirq_pkg;
  localparam int NUM_SRC   = 15;
  localparam int BYTE_W    = 8;
  localparam int ADDR_W    = 8;
  localparam int REQ_BASE  = 'h3C;
  localparam int SYNC_LEN  = 2;
endpackage

// File: rtl/mirq_edge_cap.sv
module mirq_edge_cap #(
  parameter int N     = mirq_pkg::NUM_SRC,
  parameter int DEPTH = mirq_pkg::SYNC_LEN
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] lvl_i,
  output logic [N-1:0] ev_o
);
  logic [DEPTH-1:0][N-1:0] chain_q, chain_d;
  logic [N-1:0]            last_q, last_d;

  always_comb begin
    chain_d[0] = lvl_i;
    for (int s = 1; s < DEPTH; s++) chain_d[s] = chain_q[s-1];
    last_d = chain_q[DEPTH-1];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chain_q <= '0;
      last_q  <= '0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign ev_o = chain_q[DEPTH-1] & ~last_q;

  p_single_pulse_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_o != '0) |=> ((ev_o & $past(ev_o)) == '0))
    else $error("event pulse longer than one cycle");
endmodule

// File: rtl/mirq_regfile.sv
module mirq_regfile #(
  parameter int N        = mirq_pkg::NUM_SRC,
  parameter int BYTE_W   = mirq_pkg::BYTE_W,
  parameter int ADDR_W   = mirq_pkg::ADDR_W,
  parameter int REQ_BASE = mirq_pkg::REQ_BASE,
  localparam int NBYTE   = (N + BYTE_W - 1) / BYTE_W,
  localparam int EN_BASE = REQ_BASE + NBYTE
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N-1:0]      ev_i,
  input  logic [N-1:0]      hw_clr_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic [N-1:0]      req_o,
  output logic [N-1:0]      en_o
);
  logic [N-1:0]            req_q, req_d, en_q, en_d;
  logic [N-1:0]            sw_clr, en_we, en_val;
  logic [NBYTE-1:0]        req_hit, en_hit;
  logic [NBYTE*BYTE_W-1:0] req_pad, en_pad;

  always_comb begin
    for (int b = 0; b < NBYTE; b++) begin
      req_hit[b] = wr_i && (addr_i == ADDR_W'(REQ_BASE + b));
      en_hit[b]  = wr_i && (addr_i == ADDR_W'(EN_BASE + b));
    end
  end

  for (genvar i = 0; i < N; i++) begin : g_bit
    localparam int BI = i / BYTE_W;
    localparam int PI = i % BYTE_W;
    assign sw_clr[i] = req_hit[BI] & ~wdata_i[PI];
    assign en_we[i]  = en_hit[BI];
    assign en_val[i] = wdata_i[PI];
  end

  always_comb begin
    req_d = (req_q & ~(sw_clr | hw_clr_i)) | ev_i;
    en_d  = (en_q & ~en_we) | (en_val & en_we);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= '0;
      en_q  <= '0;
    end else begin
      req_q <= req_d;
      en_q  <= en_d;
    end
  end

  always_comb begin
    req_pad = '0;
    en_pad  = '0;
    req_pad[N-1:0] = req_q;
    en_pad[N-1:0]  = en_q;
    rdata_o = '0;
    for (int b = 0; b < NBYTE; b++) begin
      if (addr_i == ADDR_W'(REQ_BASE + b)) rdata_o = req_pad[b*BYTE_W +: BYTE_W];
      if (addr_i == ADDR_W'(EN_BASE + b))  rdata_o = en_pad[b*BYTE_W +: BYTE_W];
    end
  end

  assign req_o = req_q;
  assign en_o  = en_q;

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_clr == '0 && hw_clr_i == '0) |=> ((req_q & $past(req_q)) == $past(req_q)))
    else $error("pending bit dropped without a clear");

  p_write_never_sets_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i == '0) |=> ((req_q & ~$past(req_q)) == '0))
    else $error("pending bit set without an event");

  p_ack_clears_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hw_clr_i != '0 && (hw_clr_i & ev_i) == '0) |=> ((req_q & $past(hw_clr_i)) == '0))
    else $error("acknowledged bit still pending");

  p_set_beats_clear_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i != '0) |=> ((req_q & $past(ev_i)) == $past(ev_i)))
    else $error("event lost");
endmodule

// File: rtl/mirq_prio.sv
module mirq_prio #(
  parameter int N     = mirq_pkg::NUM_SRC,
  localparam int VW   = $clog2(N)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [N-1:0]  pend_i,
  output logic          any_o,
  output logic [VW-1:0] vec_o,
  output logic [N-1:0]  grant_o
);
  always_comb begin
    vec_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (pend_i[i]) vec_o = VW'(i);
    end
    grant_o = pend_i & (~pend_i + N'(1));
    any_o   = |pend_i;
  end

  p_lowest_wins_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (pend_i[vec_o] && ((pend_i & ((N'(1) << vec_o) - N'(1))) == '0)))
    else $error("winner is not the lowest eligible source");

  p_grant_matches_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    any_o |-> (grant_o == (N'(1) << vec_o)))
    else $error("grant and index disagree");
endmodule

// File: rtl/mirq_ctrl.sv
module mirq_ctrl #(
  parameter int N_SRC    = mirq_pkg::NUM_SRC,
  parameter int BYTE_W   = mirq_pkg::BYTE_W,
  parameter int ADDR_W   = mirq_pkg::ADDR_W,
  parameter int REQ_BASE = mirq_pkg::REQ_BASE,
  parameter int SYNC_LEN = mirq_pkg::SYNC_LEN,
  localparam int VEC_W   = $clog2(N_SRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_SRC-1:0]  src_lvl_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic [BYTE_W-1:0] bus_wdata_i,
  output logic [BYTE_W-1:0] bus_rdata_o,
  input  logic              sei_i,
  input  logic              cli_i,
  input  logic              cpu_ack_i,
  output logic              irq_take_o,
  output logic [VEC_W-1:0]  irq_vec_o,
  output logic              iflag_o
);
  logic [1:0]       rsync_q;
  logic             rst_sn;
  logic [N_SRC-1:0] ev, req, en, grant, hw_clr;
  logic             any_elig, ack_take;
  logic             flag_q, flag_d;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sn = rsync_q[1];

  mirq_edge_cap #(.N(N_SRC), .DEPTH(SYNC_LEN)) u_cap (
    .clk_i (clk_i), .rst_ni(rst_sn), .lvl_i(src_lvl_i), .ev_o(ev)
  );

  mirq_regfile #(.N(N_SRC), .BYTE_W(BYTE_W), .ADDR_W(ADDR_W), .REQ_BASE(REQ_BASE)) u_regs (
    .clk_i   (clk_i),
    .rst_ni  (rst_sn),
    .ev_i    (ev),
    .hw_clr_i(hw_clr),
    .wr_i    (bus_wr_i),
    .addr_i  (bus_addr_i),
    .wdata_i (bus_wdata_i),
    .rdata_o (bus_rdata_o),
    .req_o   (req),
    .en_o    (en)
  );

  mirq_prio #(.N(N_SRC)) u_prio (
    .clk_i  (clk_i),
    .rst_ni (rst_sn),
    .pend_i (req & en),
    .any_o  (any_elig),
    .vec_o  (irq_vec_o),
    .grant_o(grant)
  );

  always_comb begin
    irq_take_o = any_elig & ~flag_q;
    ack_take   = cpu_ack_i & irq_take_o;
    hw_clr     = ack_take ? grant : '0;
    flag_d     = flag_q;
    if (cli_i)             flag_d = 1'b0;
    if (sei_i || ack_take) flag_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_sn) begin
    if (!rst_sn) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign iflag_o = flag_q;

  p_ack_sets_flag_r8: assert property (@(posedge clk_i) disable iff (!rst_sn)
    ack_take |=> flag_q)
    else $error("disable flag not set by acknowledge");

  p_cli_clears_r10: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (cli_i && !sei_i && !ack_take) |=> !flag_q)
    else $error("clear strobe ignored");

  p_sei_sets_r10: assert property (@(posedge clk_i) disable iff (!rst_sn)
    sei_i |=> flag_q)
    else $error("set strobe ignored");

  p_no_nest_r11: assert property (@(posedge clk_i) disable iff (!rst_sn)
    (ack_take && !cli_i) |=> !irq_take_o)
    else $error("nested request without clear");

  p_winner_valid_r6: assert property (@(posedge clk_i) disable iff (!rst_sn)
    irq_take_o |-> (req[irq_vec_o] && en[irq_vec_o] && !flag_q))
    else $error("request offered for ineligible source");
endmodule

// File: tb/sim_mirq_ctrl.sv
module sim_mirq_ctrl;
  localparam int CLK_P = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni;
  logic [14:0] src_lvl_i;
  logic [7:0]  bus_addr_i, bus_wdata_i, bus_rdata_o;
  logic        bus_wr_i, sei_i, cli_i, cpu_ack_i;
  logic        irq_take_o, iflag_o;
  logic [3:0]  irq_vec_o;

  typedef struct {
    int         kind;   // 0 read data, 1 take, 2 vector, 3 flag
    logic [7:0] exp;
    string      tag;
  } item_t;

  item_t sbq[$];
  event  push_ev;
  int    n_chk = 0, n_fail = 0;
  bit    done = 0;

  always #(CLK_P/2) clk_i = ~clk_i;

  mirq_ctrl u0 (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_lvl_i(src_lvl_i),
    .bus_addr_i(bus_addr_i), .bus_wr_i(bus_wr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .sei_i(sei_i), .cli_i(cli_i),
    .cpu_ack_i(cpu_ack_i), .irq_take_o(irq_take_o), .irq_vec_o(irq_vec_o),
    .iflag_o(iflag_o)
  );

  // monitor: pops expected items and compares them with the ports
  initial begin
    forever begin
      @(push_ev);
      #1;
      while (sbq.size() != 0) begin
        item_t it;
        logic [7:0] act;
        it = sbq.pop_front();
        case (it.kind)
          0: act = bus_rdata_o;
          1: act = {7'd0, irq_take_o};
          2: act = {4'd0, irq_vec_o};
          default: act = {7'd0, iflag_o};
        endcase
        n_chk++;
        if (act !== it.exp) begin
          n_fail++;
          $display("FAIL %s: kind %0d actual %0h expected %0h", it.tag, it.kind, act, it.exp);
        end
      end
    end
  end

  task automatic expect_item(input int kind, input logic [7:0] exp, input string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    sbq.push_back(it);
    -> push_ev;
  endtask

  task automatic cycles(input int n);
    repeat (n) @(negedge clk_i);
    #1;
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk_i);
    bus_addr_i = a; bus_wdata_i = d; bus_wr_i = 1'b1;
    @(negedge clk_i);
    bus_wr_i = 1'b0;
    #1;
  endtask

  task automatic read_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk_i);
    bus_addr_i = a;
    #1;
    expect_item(0, exp, tag);
  endtask

  task automatic strobe(input bit s, input bit c, input bit k);
    @(negedge clk_i);
    sei_i = s; cli_i = c; cpu_ack_i = k;
    @(negedge clk_i);
    sei_i = 0; cli_i = 0; cpu_ack_i = 0;
    #1;
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 0; src_lvl_i = '0; bus_addr_i = '0; bus_wdata_i = '0;
    bus_wr_i = 0; sei_i = 0; cli_i = 0; cpu_ack_i = 0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1;
    cycles(3);

    // R1 reset state
    read_chk(8'h3C, 8'h00, "R1 req lo");
    read_chk(8'h3D, 8'h00, "R1 req hi");
    read_chk(8'h3E, 8'h00, "R1 en lo");
    read_chk(8'h3F, 8'h00, "R1 en hi");
    expect_item(1, 0, "R1 take");
    expect_item(3, 0, "R1 flag");

    // R2 events latch while masked
    src_lvl_i[0] = 1; src_lvl_i[9] = 1;
    cycles(3);
    read_chk(8'h3C, 8'h01, "R2 src0");
    read_chk(8'h3D, 8'h02, "R2 src9");
    expect_item(1, 0, "R3 masked no take");
    src_lvl_i = '0;
    cycles(6);
    read_chk(8'h3C, 8'h01, "R3 sticky lo");
    read_chk(8'h3D, 8'h02, "R3 sticky hi");

    // R4 writes of 1 ignored, writes of 0 clear
    bus_write(8'h3C, 8'hFF);
    read_chk(8'h3C, 8'h01, "R4 write ones ignored");
    bus_write(8'h3D, 8'h00);
    read_chk(8'h3D, 8'h00, "R4 write zero clears");

    // R5 enable layout
    bus_write(8'h3E, 8'hFF);
    read_chk(8'h3E, 8'hFF, "R5 en lo");
    bus_write(8'h3F, 8'hFF);
    read_chk(8'h3F, 8'h7F, "R5 en hi bit7 zero");
    read_chk(8'h40, 8'h00, "R5 unmapped");

    // R6 / R10 flag gating
    expect_item(1, 1, "R6 take");
    expect_item(2, 0, "R7 vec0");
    strobe(1, 0, 0);
    expect_item(3, 1, "R10 sei");
    expect_item(1, 0, "R6 blocked by flag");
    strobe(0, 1, 0);
    expect_item(3, 0, "R10 cli");
    expect_item(1, 1, "R6 take again");
    strobe(1, 1, 0);
    expect_item(3, 1, "R10 both set wins");
    strobe(0, 1, 0);

    // R7 / R8 / R11 priority, ack and nesting
    src_lvl_i[5] = 1; src_lvl_i[12] = 1;
    cycles(3);
    src_lvl_i = '0;
    read_chk(8'h3C, 8'h21, "R2 src5");
    expect_item(2, 0, "R7 lowest of 0,5,12");
    strobe(0, 0, 1);
    expect_item(3, 1, "R8 flag after ack");
    expect_item(1, 0, "R11 no nest");
    read_chk(8'h3C, 8'h20, "R8 src0 cleared");
    strobe(0, 1, 0);
    expect_item(1, 1, "R11 after cli");
    expect_item(2, 5, "R7 next is 5");
    strobe(0, 0, 1);
    read_chk(8'h3C, 8'h00, "R8 src5 cleared");
    strobe(0, 1, 0);
    expect_item(2, 12, "R7 next is 12");

    // R9 event on the ack edge
    cycles(2);
    src_lvl_i[12] = 1;
    @(negedge clk_i); @(negedge clk_i);
    cpu_ack_i = 1;
    @(negedge clk_i);
    cpu_ack_i = 0;
    #1;
    read_chk(8'h3D, 8'h10, "R9 set beats clear");
    expect_item(3, 1, "R9 flag set by ack");
    src_lvl_i = '0;

    // R3 / R7 masked low index loses
    bus_write(8'h3D, 8'h00);
    bus_write(8'h3E, 8'hFE);
    strobe(0, 1, 0);
    src_lvl_i[0] = 1; src_lvl_i[14] = 1;
    cycles(3);
    src_lvl_i = '0;
    expect_item(1, 1, "R6 take src14");
    expect_item(2, 14, "R7 masked src0 loses");
    read_chk(8'h3D, 8'h40, "R2 src14 bit6");

    cycles(2);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule